// File: doc/BRIEF.md
# Signed Saturating Add/Subtract Unit

This unit adds or subtracts two 32-bit two's-complement operands and keeps a sticky saturation flag. A two-bit operation code chooses one of three modes: a wrapping add that only notes overflow, an add that clamps on overflow, and a subtract that clamps on overflow. When a clamping mode overflows, the result becomes the most negative or most positive 32-bit value. The limit is chosen by the sign of the first operand.

Each operation registers its result on a rising clock edge where `go` is high. The sticky flag `sat_flag` is set by any overflow in any mode, and stays set across later operations that do not overflow. Only the `flag_clr` input or reset brings it back to zero. Software-like control logic around the unit can read the flag after a run of arithmetic and find out whether any step in that run overflowed.

Top module: `sat_addsub`

## Requirements
- R1: After reset, `result` is 0 and `sat_flag` is 0.
- R2: With `op`=2'b00 (wrap add), `result` becomes `a+b` modulo 2^32 on the edge where `go` is high, even when the add overflows.
- R3: An add overflows when `a` and `b` have the same sign bit (bit 31) and the bit 31 of the sum differs from that of `a`.
- R4: With `op`=2'b01 (clamping add), an overflowing add yields 32'h8000_0000 if `a` is negative and 32'h7FFF_FFFF otherwise.
- R5: With `op`=2'b10 (clamping subtract), a subtract overflows when the bit 31 of `a` and `b` differ and the bit 31 of `a-b` differs from that of `a`. In that case it yields 32'h8000_0000 if `a` is negative and 32'h7FFF_FFFF otherwise.
- R6: When there is no overflow, the exact `a+b` (op 00 or 01) or `a-b` (op 10) is registered. `op`=2'b11 behaves like op 00.
- R7: Any overflow on an edge with `go` high sets `sat_flag`. No operation clears it.
- R8: `flag_clr` clears `sat_flag` on the next edge and takes priority over an overflow in the same cycle.
- R9: When `go` is low, `result` holds its value and `sat_flag` changes only through `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Perform an operation on this edge |
| op | input | 2 | 00/11 wrap add, 01 clamping add, 10 clamping subtract |
| a | input | 32 | First operand (signed) |
| b | input | 32 | Second operand (signed) |
| flag_clr | input | 1 | Clear the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong overflow decision shows up at the ports one edge after `go`, in two ways. `result` carries a clamped value where a wrapped one was expected, or the reverse. `sat_flag` rises when it should not, or fails to rise. Because the flag is sticky, a spurious set stays visible through every later check until a clear. The bench clears and rechecks the flag between scenarios, so such an error is pinned to the operation that caused it.

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         flag_clr,
  output logic [W-1:0] result,
  output logic         sat_flag
);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAXN = {1'b1, {(W-1){1'b0}}};

  logic         is_sub, clamp, ovf;
  logic [W-1:0] sum, diff, raw, nxt;

  assign is_sub = (op == 2'b10);
  assign clamp  = (op == 2'b01) || is_sub;
  assign sum    = a + b;
  assign diff   = a - b;
  assign raw    = is_sub ? diff : sum;
  assign ovf    = is_sub ? ((a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]))
                         : ((a[W-1] == b[W-1]) && (sum[W-1]  != a[W-1]));
  assign nxt    = (clamp && ovf) ? (a[W-1] ? MAXN : MAXP) : raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      sat_flag <= 1'b0;
    end else begin
      if (go) result <= nxt;
      if (flag_clr) sat_flag <= 1'b0;
      else if (go && ovf) sat_flag <= 1'b1;
    end
  end
endmodule

module sat_addsub_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic [1:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         flag_clr,
  input logic [W-1:0] result,
  input logic         sat_flag
);
  // R8
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !sat_flag);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(result));
  // R9
  no_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !sat_flag) |=> !sat_flag);
  // R4
  pos_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 2'b01 && !a[W-1] && !b[W-1]) |=> !result[W-1]);
  // R5
  neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 2'b10 && a[W-1] && !b[W-1]) |=> result[W-1]);
endmodule

bind sat_addsub sat_addsub_chk #(.W(W)) u_chk (.*);

// File: tb/sim_sat_addsub.sv
module sim_sat_addsub;
  logic        clk = 0, rst_n = 0, go = 0, flag_clr = 0;
  logic [1:0]  op = 0;
  logic [31:0] a = 0, b = 0;
  logic [31:0] result;
  logic        sat_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sat_addsub u0 (.clk, .rst_n, .go, .op, .a, .b, .flag_clr, .result, .sat_flag);

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk); op = o; a = x; b = y; go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic clear();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 result", result, 0);
    chk("R1 flag", {31'b0, sat_flag}, 0);
  endtask

  task automatic t_wrap();
    run(2'b00, 32'd5, 32'd7);
    chk("R2 sum", result, 12);
    chk("R6 no flag", {31'b0, sat_flag}, 0);
    run(2'b00, 32'h7FFF_FFFF, 32'd1);
    chk("R2 wrap", result, 32'h8000_0000);
    chk("R3 flag", {31'b0, sat_flag}, 1);
    clear();
    run(2'b11, 32'h8000_0000, 32'hFFFF_FFFF);
    chk("R6 op11 wrap", result, 32'h7FFF_FFFF);
    chk("R3 neg flag", {31'b0, sat_flag}, 1);
    clear();
    run(2'b00, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    chk("R3 mixed sign", {31'b0, sat_flag}, 0);
  endtask

  task automatic t_sat_add();
    run(2'b01, 32'h7000_0000, 32'h2000_0000);
    chk("R4 pos", result, 32'h7FFF_FFFF);
    chk("R7 set", {31'b0, sat_flag}, 1);
    run(2'b01, 32'd3, 32'hFFFF_FFFE);
    chk("R6 exact", result, 1);
    chk("R7 sticky", {31'b0, sat_flag}, 1);
    clear();
    run(2'b01, 32'h8000_0001, 32'h8000_0000);
    chk("R4 neg", result, 32'h8000_0000);
  endtask

  task automatic t_sat_sub();
    clear();
    run(2'b10, 32'd10, 32'd15);
    chk("R6 sub", result, 32'hFFFF_FFFB);
    chk("R5 no flag", {31'b0, sat_flag}, 0);
    run(2'b10, 32'h7FFF_FFF0, 32'hF000_0000);
    chk("R5 pos", result, 32'h7FFF_FFFF);
    chk("R5 flag", {31'b0, sat_flag}, 1);
    clear();
    run(2'b10, 32'h9000_0000, 32'h2000_0000);
    chk("R5 neg", result, 32'h8000_0000);
    clear();
    run(2'b10, 32'h0, 32'h8000_0000);
    chk("R5 zero minus min", result, 32'h7FFF_FFFF);
  endtask

  task automatic t_clr_prio();
    clear();
    @(negedge clk); op = 2'b01; a = 32'h7FFF_FFFF; b = 32'h7FFF_FFFF; go = 1; flag_clr = 1;
    @(negedge clk); go = 0; flag_clr = 0;
    chk("R8 clear wins", {31'b0, sat_flag}, 0);
    chk("R8 result still", result, 32'h7FFF_FFFF);
  endtask

  task automatic t_idle();
    run(2'b00, 32'd100, 32'd1);
    @(negedge clk); op = 2'b00; a = 32'h7FFF_FFFF; b = 32'h7FFF_FFFF;
    @(negedge clk); @(negedge clk);
    chk("R9 hold", result, 101);
    chk("R9 no flag", {31'b0, sat_flag}, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #20; t_reset();
    @(negedge clk); rst_n = 1;
    t_wrap(); t_sat_add(); t_sat_sub(); t_clr_prio(); t_idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule